// File: doc/BRIEF.md
# Translation Cache with Access Permission Checking

This block is a small fully associative translation cache for 4 KB pages. A requester presents a virtual address, the kind of access (read, write or instruction fetch), its privilege level and an address space tag. In the same cycle the block compares the page number against every valid entry at once. On a match it returns the physical address, built from the stored frame number and the untouched 12-bit page offset. It also checks the stored permissions and reports a protection fault together with a cause code.

When no entry matches, the block raises a miss request that carries the page number. The requester keeps its request asserted while an external walker fetches the mapping and writes it through the refill port. The refill lands on the clock edge, and from the next cycle the same held request is answered from the new entry. Refills go to a victim slot picked round robin. Entries are removed by a full flush, by a flush that spares entries marked global (used on a context switch), or by a single-page invalidate that removes every entry for one page number. Three free-running counters record hits, misses and protection faults.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, the victim slot is 0 and all three counters read 0, so the first request misses.
- R2: The page number is address bits [31:12]. An entry matches when it is valid, its page number is equal, and it is global or its address space tag equals the request's. On a match, rsp_hit is 1 in the same cycle and rsp_paddr = {frame, vaddr[11:0]} when there is no fault.
- R3: With req_valid high and no matching entry, miss_req is 1, rsp_hit is 0 and miss_vpn equals vaddr[31:12]. A refill written while the request is held makes that same request hit from the next cycle.
- R4: Each refill writes the slot the victim pointer names, and the pointer then advances by one modulo 16. The 17th refill after a full set therefore replaces the oldest entry and leaves the others.
- R5: A user access (req_user=1) to an entry without user permission faults with cause 1. This check wins over the two below.
- R6: A write (req_kind=01) to an entry without write permission faults with cause 2, unless R5 already applies. This holds at either privilege level.
- R7: An instruction fetch (req_kind=10) to an entry without execute permission faults with cause 3, unless R5 or R6 applies. A read is req_kind=00. With any fault, rsp_fault is 1, rsp_hit stays 1 and rsp_paddr is 0. With no fault, the cause is 0.
- R8: A non-global entry does not match a request that carries a different address space tag. A global entry matches any tag.
- R9: flush_all makes every entry invalid. flush_local makes every non-global entry invalid and keeps the global ones.
- R10: inval_en makes invalid every entry whose page number equals inval_vpn, whatever its tag.
- R11: On each clock edge with req_valid high, exactly one of cnt_hit and cnt_miss increases by 1. cnt_fault also increases by 1 when the hit faults. The counters wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| req_user | input | 1 | 1 = user level, 0 = kernel level |
| req_asid | input | 8 | Address space tag of the request |
| rsp_hit | output | 1 | Request matched an entry |
| rsp_fault | output | 1 | Matched entry forbids this access |
| rsp_cause | output | 2 | 0 none, 1 privilege, 2 write, 3 fetch |
| rsp_paddr | output | 32 | Physical address, 0 on fault or miss |
| miss_req | output | 1 | Walk needed for miss_vpn |
| miss_vpn | output | 20 | Page number that missed |
| refill_en | input | 1 | Write a translation into the victim slot |
| refill_vpn | input | 20 | Page number to store |
| refill_pfn | input | 20 | Frame number to store |
| refill_asid | input | 8 | Address space tag to store |
| refill_wr | input | 1 | Write permitted |
| refill_usr | input | 1 | User access permitted |
| refill_exe | input | 1 | Fetch permitted |
| refill_glb | input | 1 | Entry is global |
| flush_all | input | 1 | Invalidate every entry |
| flush_local | input | 1 | Invalidate non-global entries |
| inval_en | input | 1 | Invalidate entries for one page |
| inval_vpn | input | 20 | Page number to invalidate |
| cnt_hit | output | 16 | Hit count |
| cnt_miss | output | 16 | Miss count |
| cnt_fault | output | 16 | Protection fault count |

## Verification
Lookups are combinational over registered entries. A corrupted valid bit, tag, tag comparison or permission bit therefore appears at the ports in the very cycle the affected page is next requested: as a wrong hit or miss, a wrong frame in rsp_paddr, or a wrong cause code. A victim pointer that steps wrongly stays hidden until the table wraps. It shows up as the wrong page being evicted on the seventeenth refill, so the bench fills the whole table and checks exactly which page dropped out. Counter faults show up one edge after the request they should count.

// File: rtl/xlat_pkg.sv
// Shared types for the translation cache.
// Assumes: 2-bit access kind and 2-bit fault cause encodings fixed here.
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_kind_e;

    // Cause encoding is visible at the ports; order mirrors check priority.
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_PRIV  = 2'd1,
        CAUSE_WRITE = 2'd2,
        CAUSE_FETCH = 2'd3
    } fault_cause_e;

    typedef struct packed {
        logic wr;
        logic usr;
        logic exe;
        logic glb;
    } perm_t;

endpackage

// File: rtl/xlat_entry_array.sv
// Entry storage, parallel match and replacement for the translation cache.
// Assumes: at most one entry matches a lookup. If several do, the lowest
// index wins. A refill in the same cycle as a flush or invalidate survives.
module xlat_entry_array
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output perm_t             lk_perm,
    input  logic              refill_en,
    input  logic [VPN_W-1:0]  refill_vpn,
    input  logic [PFN_W-1:0]  refill_pfn,
    input  logic [ASID_W-1:0] refill_asid,
    input  perm_t             refill_perm,
    input  logic              flush_all,
    input  logic              flush_local,
    input  logic              inval_en,
    input  logic [VPN_W-1:0]  inval_vpn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q, valid_d, match;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    logic [ASID_W-1:0]  asid_q [ENTRIES];
    perm_t              perm_q [ENTRIES];
    logic [IDX_W-1:0]   victim_q;

    // One comparator per entry, all evaluated together.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn) &&
                          (perm_q[g].glb || (asid_q[g] == lk_asid));
    end

    // Pick the lowest matching entry's frame and permissions.
    always_comb begin
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_pfn  = pfn_q[i];
                lk_perm = perm_q[i];
            end
        end
    end
    assign lk_hit = |match;

    // Next valid bits: removals first, then the refill slot is set.
    always_comb begin
        valid_d = valid_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (flush_all || (flush_local && !perm_q[i].glb) ||
                (inval_en && (vpn_q[i] == inval_vpn)))
                valid_d[i] = 1'b0;
        end
        if (refill_en)
            valid_d[victim_q] = 1'b1;
    end

    // Register valid bits and the round-robin victim pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            victim_q <= '0;
        end else begin
            valid_q <= valid_d;
            if (refill_en)
                victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
        end
    end

    // Write the translation payload into the victim slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i]  <= '0;
                pfn_q[i]  <= '0;
                asid_q[i] <= '0;
                perm_q[i] <= '0;
            end
        end else if (refill_en) begin
            vpn_q[victim_q]  <= refill_vpn;
            pfn_q[victim_q]  <= refill_pfn;
            asid_q[victim_q] <= refill_asid;
            perm_q[victim_q] <= refill_perm;
        end
    end

    // R4
    victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_en |=> victim_q == (($past(victim_q) == LAST) ? '0 : $past(victim_q) + 1'b1));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !refill_en) |=> (valid_q == '0));

    // R4
    refill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_en |=> valid_q[$past(victim_q)]);

endmodule

// File: rtl/xlat_perm_check.sv
// Access permission check on a matched entry.
// Assumes: the perm input is meaningful only when the lookup hit.
// Priority: privilege, then write protection, then fetch protection.
module xlat_perm_check
    import xlat_pkg::*;
(
    input  acc_kind_e    kind,
    input  logic         user,
    input  perm_t        perm,
    output fault_cause_e cause
);
    // Fixed-priority fault selection.
    always_comb begin
        if (user && !perm.usr)
            cause = CAUSE_PRIV;
        else if (kind == ACC_WRITE && !perm.wr)
            cause = CAUSE_WRITE;
        else if (kind == ACC_FETCH && !perm.exe)
            cause = CAUSE_FETCH;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/xlat_counters.sv
// Bank of wrapping event counters, one per increment input.
// Assumes: each increment is a one-cycle pulse per event.
module xlat_counters #(
    parameter int NUM   = 3,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt_q
);
    for (genvar k = 0; k < NUM; k++) begin : g_cnt
        // Count one event per cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[k] <= '0;
            else if (inc[k])
                cnt_q[k] <= cnt_q[k] + 1'b1;
        end

        // R11
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            inc[k] |=> cnt_q[k] == CNT_W'($past(cnt_q[k]) + 1'b1));
    end
endmodule

// File: rtl/xlat_cache.sv
// Translation cache top: fully associative lookup, permission check,
// miss request, refill, flushes, invalidate and event counters.
// Assumes: 4 KB pages. The requester holds a missing request until the
// refill is written, and the response is combinational in that cycle.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [VA_W-1:0]             req_vaddr,
    input  logic [1:0]                  req_kind,
    input  logic                        req_user,
    input  logic [ASID_W-1:0]           req_asid,
    output logic                        rsp_hit,
    output logic                        rsp_fault,
    output logic [1:0]                  rsp_cause,
    output logic [PFN_W+11:0]           rsp_paddr,
    output logic                        miss_req,
    output logic [VA_W-13:0]            miss_vpn,
    input  logic                        refill_en,
    input  logic [VA_W-13:0]            refill_vpn,
    input  logic [PFN_W-1:0]            refill_pfn,
    input  logic [ASID_W-1:0]           refill_asid,
    input  logic                        refill_wr,
    input  logic                        refill_usr,
    input  logic                        refill_exe,
    input  logic                        refill_glb,
    input  logic                        flush_all,
    input  logic                        flush_local,
    input  logic                        inval_en,
    input  logic [VA_W-13:0]            inval_vpn,
    output logic [CNT_W-1:0]            cnt_hit,
    output logic [CNT_W-1:0]            cnt_miss,
    output logic [CNT_W-1:0]            cnt_fault
);
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;

    logic [VPN_W-1:0]        req_vpn;
    logic                    arr_hit;
    logic [PFN_W-1:0]        arr_pfn;
    perm_t                   arr_perm, refill_perm;
    fault_cause_e            chk_cause;
    logic [2:0][CNT_W-1:0]   cnts;

    assign req_vpn     = req_vaddr[VA_W-1:OFF_W];
    assign refill_perm = '{wr: refill_wr, usr: refill_usr, exe: refill_exe, glb: refill_glb};

    xlat_entry_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(req_vpn), .lk_asid(req_asid),
        .lk_hit(arr_hit), .lk_pfn(arr_pfn), .lk_perm(arr_perm),
        .refill_en(refill_en), .refill_vpn(refill_vpn), .refill_pfn(refill_pfn),
        .refill_asid(refill_asid), .refill_perm(refill_perm),
        .flush_all(flush_all), .flush_local(flush_local),
        .inval_en(inval_en), .inval_vpn(inval_vpn)
    );

    xlat_perm_check u_perm (
        .kind(acc_kind_e'(req_kind)), .user(req_user),
        .perm(arr_perm), .cause(chk_cause)
    );

    // Response shaping: gate by request, zero the address on fault.
    always_comb begin
        rsp_hit   = req_valid && arr_hit;
        miss_req  = req_valid && !arr_hit;
        miss_vpn  = miss_req ? req_vpn : '0;
        rsp_cause = rsp_hit ? chk_cause : CAUSE_NONE;
        rsp_fault = (rsp_cause != CAUSE_NONE);
        rsp_paddr = (rsp_hit && !rsp_fault) ? {arr_pfn, req_vaddr[OFF_W-1:0]} : '0;
    end

    xlat_counters #(.NUM(3), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc({rsp_fault, miss_req, rsp_hit}),
        .cnt_q(cnts)
    );
    assign cnt_hit   = cnts[0];
    assign cnt_miss  = cnts[1];
    assign cnt_fault = cnts[2];

    // R3
    hit_or_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot({rsp_hit, miss_req}));

    // R7
    fault_blocks_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_hit && rsp_paddr == '0));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(rsp_hit || miss_req || rsp_fault));

endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 0;
    logic [7:0]  req_asid = '0;
    logic        rsp_hit, rsp_fault, miss_req;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_paddr;
    logic [19:0] miss_vpn;
    logic        refill_en = 0;
    logic [19:0] refill_vpn = '0, refill_pfn = '0, inval_vpn = '0;
    logic [7:0]  refill_asid = '0;
    logic        refill_wr = 0, refill_usr = 0, refill_exe = 0, refill_glb = 0;
    logic        flush_all = 0, flush_local = 0, inval_en = 0;
    logic [15:0] cnt_hit, cnt_miss, cnt_fault;

    int checks = 0, fails = 0;
    int exp_h = 0, exp_m = 0, exp_f = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xlat_cache u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-edge lookup. Checks the response and tracks expected counters.
    task automatic lookup(string req, logic [31:0] va, logic [1:0] kind, logic user,
                          logic [7:0] asid, logic ehit, logic [1:0] ecause, logic [19:0] epfn);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_kind = kind; req_user = user; req_asid = asid;
        #5;
        chk({req, " hit"}, 32'(rsp_hit), 32'(ehit));
        chk({req, " miss"}, 32'(miss_req), 32'(!ehit));
        if (!ehit) chk({req, " miss_vpn"}, 32'(miss_vpn), 32'(va[31:12]));
        chk({req, " cause"}, 32'(rsp_cause), 32'(ecause));
        chk({req, " fault"}, 32'(rsp_fault), 32'(ecause != 0));
        chk({req, " paddr"}, rsp_paddr, (ehit && ecause == 0) ? {epfn, va[11:0]} : 32'h0);
        if (ehit) exp_h++; else exp_m++;
        if (ecause != 0) exp_f++;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic refill(logic [19:0] vpn, logic [19:0] pfn, logic [7:0] asid,
                          logic wr, logic usr, logic exe, logic glb);
        @(negedge clk);
        refill_en = 1; refill_vpn = vpn; refill_pfn = pfn; refill_asid = asid;
        refill_wr = wr; refill_usr = usr; refill_exe = exe; refill_glb = glb;
        @(negedge clk);
        refill_en = 0;
    endtask

    task automatic pulse_flush(logic all, logic local_only);
        @(negedge clk);
        flush_all = all; flush_local = local_only;
        @(negedge clk);
        flush_all = 0; flush_local = 0;
    endtask

    task automatic check_counters(string tag);
        chk({tag, " R11 hits"}, 32'(cnt_hit), 32'(exp_h));
        chk({tag, " R11 misses"}, 32'(cnt_miss), 32'(exp_m));
        chk({tag, " R11 faults"}, 32'(cnt_fault), 32'(exp_f));
    endtask

    task automatic t_reset;
        #5;
        check_counters("R1 reset");
        lookup("R1 first", 32'h0001_2345, 2'b00, 1, 8'd0, 0, 0, 0);
    endtask

    // R3: hold a missing request, refill during it, then it hits.
    task automatic t_held_miss;
        @(negedge clk);
        req_valid = 1; req_vaddr = 32'h0004_2ABC; req_kind = 2'b00; req_user = 1; req_asid = 8'd1;
        #5;
        chk("R3 held miss", 32'(miss_req), 1);
        chk("R3 miss_vpn", 32'(miss_vpn), 32'h42);
        @(negedge clk);
        chk("R3 still miss", 32'(miss_req), 1);
        refill_en = 1; refill_vpn = 20'h42; refill_pfn = 20'h5A2; refill_asid = 8'd1;
        refill_wr = 1; refill_usr = 1; refill_exe = 0; refill_glb = 0;
        exp_m += 2;
        @(negedge clk);
        refill_en = 0;
        #5;
        chk("R3 reeval hit", 32'(rsp_hit), 1);
        chk("R2 paddr", rsp_paddr, 32'h005A_2ABC);
        exp_h++;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_perms;
        refill(20'h64, 20'hFFF, 8'd1, 1, 0, 1, 0);   // kernel-only page
        refill(20'h01, 20'h101, 8'd1, 0, 1, 0, 0);   // read-only, no fetch
        refill(20'h02, 20'h102, 8'd1, 0, 0, 0, 0);   // nothing allowed
        lookup("R5 user on kernel page", 32'h0006_4010, 2'b00, 1, 8'd1, 1, 1, 0);
        lookup("R2 kernel read", 32'h0006_4010, 2'b00, 0, 8'd1, 1, 0, 20'hFFF);
        lookup("R6 user write ro", 32'h0000_1100, 2'b01, 1, 8'd1, 1, 2, 0);
        lookup("R6 kernel write ro", 32'h0000_1100, 2'b01, 0, 8'd1, 1, 2, 0);
        lookup("R7 fetch nx", 32'h0000_1200, 2'b10, 1, 8'd1, 1, 3, 0);
        lookup("R7 read ok", 32'h0000_1FFF, 2'b00, 1, 8'd1, 1, 0, 20'h101);
        lookup("R5 priv beats write", 32'h0000_2000, 2'b01, 1, 8'd1, 1, 1, 0);
        lookup("R6 write beats fetch", 32'h0000_2000, 2'b01, 0, 8'd1, 1, 2, 0);
        lookup("R7 fetch kernel", 32'h0000_2000, 2'b10, 0, 8'd1, 1, 3, 0);
    endtask

    task automatic t_asid_flush;
        refill(20'h300, 20'h0A0, 8'd3, 1, 1, 1, 0);
        refill(20'h301, 20'h0A1, 8'd3, 1, 1, 1, 1);
        lookup("R8 same tag", 32'h0030_0004, 2'b00, 1, 8'd3, 1, 0, 20'h0A0);
        lookup("R8 other tag", 32'h0030_0004, 2'b00, 1, 8'd4, 0, 0, 0);
        lookup("R8 global any tag", 32'h0030_1008, 2'b00, 1, 8'd4, 1, 0, 20'h0A1);
        pulse_flush(0, 1);
        lookup("R9 local flushed", 32'h0030_0004, 2'b00, 1, 8'd3, 0, 0, 0);
        lookup("R9 global kept", 32'h0030_1008, 2'b00, 1, 8'd3, 1, 0, 20'h0A1);
        pulse_flush(1, 0);
        lookup("R9 global flushed", 32'h0030_1008, 2'b00, 1, 8'd3, 0, 0, 0);
    endtask

    task automatic t_inval;
        refill(20'h400, 20'h0B0, 8'd1, 1, 1, 1, 0);
        refill(20'h400, 20'h0B1, 8'd2, 1, 1, 1, 0);
        refill(20'h401, 20'h0B2, 8'd1, 1, 1, 1, 0);
        @(negedge clk);
        inval_en = 1; inval_vpn = 20'h400;
        @(negedge clk);
        inval_en = 0;
        lookup("R10 tag1 gone", 32'h0040_0000, 2'b00, 1, 8'd1, 0, 0, 0);
        lookup("R10 tag2 gone", 32'h0040_0000, 2'b00, 1, 8'd2, 0, 0, 0);
        lookup("R10 neighbour kept", 32'h0040_1000, 2'b00, 1, 8'd1, 1, 0, 20'h0B2);
    endtask

    // R4: fill every slot, then one more evicts exactly the oldest.
    task automatic t_round_robin;
        pulse_flush(1, 0);
        for (int k = 0; k < 16; k++)
            refill(20'h100 + 20'(k), 20'h200 + 20'(k), 8'd0, 1, 1, 1, 0);
        lookup("R4 first present", 32'h0010_0000, 2'b00, 0, 8'd0, 1, 0, 20'h200);
        lookup("R4 last present", 32'h0010_F000, 2'b00, 0, 8'd0, 1, 0, 20'h20F);
        refill(20'h110, 20'h210, 8'd0, 1, 1, 1, 0);
        lookup("R4 oldest evicted", 32'h0010_0000, 2'b00, 0, 8'd0, 0, 0, 0);
        lookup("R4 second kept", 32'h0010_1000, 2'b00, 0, 8'd0, 1, 0, 20'h201);
        lookup("R4 new present", 32'h0011_0ABC, 2'b00, 0, 8'd0, 1, 0, 20'h210);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_held_miss();
        t_perms();
        t_asid_flush();
        t_inval();
        t_round_robin();
        @(negedge clk);
        check_counters("end");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule